// File: doc/BRIEF.md
# Vector String Range Compare Unit

This execution unit scans a 128-bit vector of string elements and tests every element against a set of range bounds. The bound vector is read in adjacent pairs. Each bound has its own three-way acceptance control: equal, source below the bound, and source above the bound. An element matches when both bounds of at least one pair accept it. The result can be inverted. A search for a zero (terminator) element can be switched on, and it limits which matches are reported.

The unit returns one of two results. In index mode it gives the byte offset of the first reported hit. In mask mode it gives a per-element mask with every matching element set to all ones. It can also produce a two-bit condition code that summarises how matches and the terminator relate. The element width is 8, 16 or 32 bits. An illegal width code raises a specification-exception flag. Operands arrive with a one-cycle valid pulse, and all outputs are registered one clock later.

Top module: `vsrc_unit`

## Requirements
- R1: `elem_size` codes 0, 1 and 2 select 8-, 16- and 32-bit elements. Any code of 3 or more sets `spec_err` and keeps `result` at its previous value. In that case `cc_valid` is 0 and `cc` is 0. A legal code clears `spec_err`.
- R2: Element 0 occupies the most significant bits of each operand. Element i of s bytes lies at bits [127-8*s*i -: 8*s], and its byte offset is i*s.
- R3: The control for bound j is the most significant byte of element j of `ctl_vec`. In that byte, bit 7 accepts source equal to bound, bit 6 accepts source less than bound and bit 5 accepts source greater than bound. All comparisons are unsigned.
- R4: Bounds are paired as (0,1), (2,3) and so on. An element matches when both bounds of any one pair accept it.
- R5: `modifier` bit 3 inverts every per-element match result.
- R6: `modifier` bit 1 enables the zero search. The first-zero offset is the byte offset of the lowest all-zero element. It is 16 when no element is all zero or when the search is off.
- R7: With `modifier` bit 2 clear (index mode), only matches below the first-zero offset count. `result[127:64]` holds the smaller of the first-match offset (16 if none) and the first-zero offset, and `result[63:0]` is zero.
- R8: With `modifier` bit 2 set (mask mode), every matching element is all ones and every other element is zero, including elements after a zero. The first-match offset is that of the lowest matching element.
- R9: With `modifier` bit 0 set, `cc_valid` is 1. `cc` is 3 when there is no match and no zero, and 1 when there is a match but no zero. It is 2 when the first match lies below the first zero, and 0 otherwise.
- R10: With `modifier` bit 0 clear, `cc_valid` is 0 and `cc` is 0.
- R11: An `in_valid` pulse gives `out_valid` high on the next cycle only, with the new outputs. Between operations all other outputs hold their values.
- R12: Reset is synchronous and active low. It clears `out_valid`, `result`, `cc`, `cc_valid` and `spec_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands valid this cycle |
| elem_size | input | 4 | Element width code |
| modifier | input | 4 | Bit 3 invert, bit 2 mask mode, bit 1 zero search, bit 0 condition code |
| src_vec | input | 128 | String elements |
| bnd_vec | input | 128 | Range bounds |
| ctl_vec | input | 128 | Per-bound acceptance controls |
| out_valid | output | 1 | Result valid pulse |
| result | output | 128 | Index or mask result |
| cc | output | 2 | Condition code |
| cc_valid | output | 1 | Condition code produced |
| spec_err | output | 1 | Illegal element width |

## Verification
The bench builds the unit with its default parameters: a 16-byte vector and three element widths. This puts every width lane and the illegal-code path within reach. Random operands use bytes drawn mostly from a tiny value set, so equal comparisons and all-zero elements occur often at all three widths. Directed operations cover the four condition codes, a terminator before and after the first match, inversion, and a comparison that only passes when treated as unsigned.

// File: rtl/vsrc_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and the single-bound acceptance function of the
// range-compare unit. Assumes bounds and data are at most 32 bits wide.
package vsrc_pkg;
    localparam int MOD_CC   = 0;   // modifier bit: produce condition code
    localparam int MOD_ZS   = 1;   // modifier bit: zero search
    localparam int MOD_MASK = 2;   // modifier bit: mask output
    localparam int MOD_INV  = 3;   // modifier bit: invert matches

    localparam int CTL_EQ = 7;     // control byte bit: accept equal
    localparam int CTL_LT = 6;     // control byte bit: accept source < bound
    localparam int CTL_GT = 5;     // control byte bit: accept source > bound

    localparam logic [1:0] CC_ZERO_FIRST = 2'd0;
    localparam logic [1:0] CC_HIT_NOZERO = 2'd1;
    localparam logic [1:0] CC_HIT_FIRST  = 2'd2;
    localparam logic [1:0] CC_NOTHING    = 2'd3;

    // Unsigned three-way compare of one element against one bound.
    function automatic logic bound_accept(input logic [31:0] data,
                                          input logic [31:0] bound,
                                          input logic [7:0]  ctl);
        if (data < bound)      return ctl[CTL_LT];
        else if (data > bound) return ctl[CTL_GT];
        else                   return ctl[CTL_EQ];
    endfunction
endpackage

// File: rtl/vsrc_size_lane.sv
`timescale 1ns/1ps
// Module: one element-width lane. Splits the operands into elements of
// ELEM_BYTES bytes (element 0 at the MSB), tests each element against every
// bound pair, and reports per-byte flags indexed by byte offset.
// Assumes VEC_BYTES is a multiple of 2*ELEM_BYTES and ELEM_BYTES <= 4.
module vsrc_size_lane #(
    parameter int VEC_BYTES  = 16,
    parameter int ELEM_BYTES = 1
) (
    input  logic [8*VEC_BYTES-1:0] src,
    input  logic [8*VEC_BYTES-1:0] bnd,
    input  logic [8*VEC_BYTES-1:0] ctl,
    input  logic                   invert,
    output logic [VEC_BYTES-1:0]   hit_lead,   // set on first byte of a matching element
    output logic [VEC_BYTES-1:0]   zero_lead,  // set on first byte of an all-zero element
    output logic [VEC_BYTES-1:0]   hit_bytes   // set on every byte of a matching element
);
    import vsrc_pkg::*;

    localparam int VEC_W = 8 * VEC_BYTES;
    localparam int EW    = 8 * ELEM_BYTES;
    localparam int NELEM = VEC_BYTES / ELEM_BYTES;
    localparam int PAIRS = NELEM / 2;

    // Low control bytes of wide elements carry no meaning.
    logic unused_ctl;
    assign unused_ctl = ^ctl;

    for (genvar e = 0; e < NELEM; e++) begin : g_elem
        logic [EW-1:0]    data;
        logic [PAIRS-1:0] pair_ok;
        logic             elem_hit;

        assign data = src[VEC_W-1-EW*e -: EW];

        for (genvar p = 0; p < PAIRS; p++) begin : g_pair
            logic acc_lo, acc_hi;
            // Both bounds of pair p must accept the element.
            assign acc_lo = bound_accept(32'(data), 32'(bnd[VEC_W-1-EW*(2*p) -: EW]),
                                         ctl[VEC_W-1-EW*(2*p) -: 8]);
            assign acc_hi = bound_accept(32'(data), 32'(bnd[VEC_W-1-EW*(2*p+1) -: EW]),
                                         ctl[VEC_W-1-EW*(2*p+1) -: 8]);
            assign pair_ok[p] = acc_lo & acc_hi;
        end

        assign elem_hit = (|pair_ok) ^ invert;

        for (genvar k = 0; k < ELEM_BYTES; k++) begin : g_byte
            assign hit_bytes[e*ELEM_BYTES+k] = elem_hit;
            assign hit_lead[e*ELEM_BYTES+k]  = (k == 0) ? elem_hit : 1'b0;
            assign zero_lead[e*ELEM_BYTES+k] = (k == 0) ? (data == '0) : 1'b0;
        end
    end
endmodule

// File: rtl/vsrc_first_pos.sv
`timescale 1ns/1ps
// Module: lowest-set-bit finder. Returns the index of the lowest set bit of
// vec, or WIDTH when no bit is set. Assumes IDX_W can represent WIDTH.
module vsrc_first_pos #(
    parameter int WIDTH = 16,
    parameter int IDX_W = $clog2(WIDTH + 1)
) (
    input  logic [WIDTH-1:0] vec,
    output logic [IDX_W-1:0] pos
);
    // Scan from the top so the lowest set bit wins.
    always_comb begin
        pos = IDX_W'(WIDTH);
        for (int i = WIDTH - 1; i >= 0; i--) begin
            if (vec[i]) pos = IDX_W'(i);
        end
    end
endmodule

// File: rtl/vsrc_unit.sv
`timescale 1ns/1ps
// Module: vector string range-compare unit (top). Builds one lane per
// element width, selects the lane named by elem_size, derives first-match
// and first-zero byte offsets, forms the index or mask result and the
// condition code, and registers everything one cycle after in_valid.
// Assumes operands are stable while in_valid is high; reset is synchronous
// and active low.
module vsrc_unit #(
    parameter int VEC_BYTES = 16,
    parameter int NUM_SIZES = 3,
    parameter int SIZE_W    = 4,
    parameter int MOD_W     = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [SIZE_W-1:0]      elem_size,
    input  logic [MOD_W-1:0]       modifier,
    input  logic [8*VEC_BYTES-1:0] src_vec,
    input  logic [8*VEC_BYTES-1:0] bnd_vec,
    input  logic [8*VEC_BYTES-1:0] ctl_vec,
    output logic                   out_valid,
    output logic [8*VEC_BYTES-1:0] result,
    output logic [1:0]             cc,
    output logic                   cc_valid,
    output logic                   spec_err
);
    import vsrc_pkg::*;

    localparam int VEC_W  = 8 * VEC_BYTES;
    localparam int HALF_W = VEC_W / 2;
    localparam int IDX_W  = $clog2(VEC_BYTES + 1);

    logic [VEC_BYTES-1:0] lane_hit_lead  [NUM_SIZES];
    logic [VEC_BYTES-1:0] lane_zero_lead [NUM_SIZES];
    logic [VEC_BYTES-1:0] lane_hit_bytes [NUM_SIZES];

    for (genvar g = 0; g < NUM_SIZES; g++) begin : g_lane
        vsrc_size_lane #(
            .VEC_BYTES (VEC_BYTES),
            .ELEM_BYTES(1 << g)
        ) u_lane (
            .src      (src_vec),
            .bnd      (bnd_vec),
            .ctl      (ctl_vec),
            .invert   (modifier[MOD_INV]),
            .hit_lead (lane_hit_lead[g]),
            .zero_lead(lane_zero_lead[g]),
            .hit_bytes(lane_hit_bytes[g])
        );
    end

    logic                 size_ok;
    logic [VEC_BYTES-1:0] sel_hit_lead, sel_zero_lead, sel_hit_bytes;

    assign size_ok = (elem_size < SIZE_W'(NUM_SIZES));

    // Pick the lane of the requested element width.
    always_comb begin
        sel_hit_lead  = '0;
        sel_zero_lead = '0;
        sel_hit_bytes = '0;
        for (int g = 0; g < NUM_SIZES; g++) begin
            if (elem_size == SIZE_W'(g)) begin
                sel_hit_lead  = lane_hit_lead[g];
                sel_zero_lead = lane_zero_lead[g];
                sel_hit_bytes = lane_hit_bytes[g];
            end
        end
    end

    logic [VEC_BYTES-1:0] zero_req;
    logic [IDX_W-1:0]     raw_match_pos, zero_pos;

    assign zero_req = modifier[MOD_ZS] ? sel_zero_lead : '0;

    vsrc_first_pos #(.WIDTH(VEC_BYTES), .IDX_W(IDX_W)) u_match_pos (
        .vec(sel_hit_lead),
        .pos(raw_match_pos)
    );

    vsrc_first_pos #(.WIDTH(VEC_BYTES), .IDX_W(IDX_W)) u_zero_pos (
        .vec(zero_req),
        .pos(zero_pos)
    );

    logic [IDX_W-1:0] match_pos, near_pos;
    logic [VEC_W-1:0] mask_vec, next_result;
    logic [1:0]       next_cc;
    logic             no_match, no_zero;

    // Index mode ignores matches at or beyond the terminator.
    always_comb begin
        if (!modifier[MOD_MASK] && (raw_match_pos >= zero_pos))
            match_pos = IDX_W'(VEC_BYTES);
        else
            match_pos = raw_match_pos;
        near_pos = (match_pos < zero_pos) ? match_pos : zero_pos;
    end

    for (genvar b = 0; b < VEC_BYTES; b++) begin : g_mask
        assign mask_vec[VEC_W-1-8*b -: 8] = {8{sel_hit_bytes[b]}};
    end

    // Result form chosen by the mask-mode modifier bit.
    always_comb begin
        if (modifier[MOD_MASK]) next_result = mask_vec;
        else                    next_result = {HALF_W'(near_pos), {HALF_W{1'b0}}};
    end

    assign no_match = (match_pos == IDX_W'(VEC_BYTES));
    assign no_zero  = (zero_pos  == IDX_W'(VEC_BYTES));

    // Four-way condition code from the two offsets.
    always_comb begin
        if (no_match && no_zero)      next_cc = CC_NOTHING;
        else if (no_zero)             next_cc = CC_HIT_NOZERO;
        else if (match_pos < zero_pos) next_cc = CC_HIT_FIRST;
        else                          next_cc = CC_ZERO_FIRST;
    end

    // Output registers: capture on in_valid, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
            cc        <= 2'b00;
            cc_valid  <= 1'b0;
            spec_err  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                spec_err <= !size_ok;
                if (size_ok) result <= next_result;
                cc_valid <= size_ok && modifier[MOD_CC];
                cc       <= (size_ok && modifier[MOD_CC]) ? next_cc : 2'b00;
            end
        end
    end

    // R11: one-cycle output pulse per accepted operation.
    p_valid_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_valid_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R1: an illegal width flags an exception and leaves the result alone.
    p_spec_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && elem_size >= SIZE_W'(NUM_SIZES)) |=>
            (spec_err && $stable(result) && !cc_valid));
    // R10: condition code reads zero whenever it is not produced.
    p_cc_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !cc_valid) |-> (cc == 2'b00));
    // R9: a legal request with the code bit set yields a valid code.
    p_cc_given_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && size_ok && modifier[MOD_CC]) |=> cc_valid);
    // R7: index form has a zero low half and an offset no larger than the vector.
    p_index_form_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && size_ok && !modifier[MOD_MASK]) |=>
            ((result[HALF_W-1:0] == '0) &&
             (result[VEC_W-1:HALF_W] <= HALF_W'(VEC_BYTES))));
endmodule

// File: tb/tb_vsrc_unit.sv
`timescale 1ns/1ps
// Bench: directed corner cases plus seeded random operations, each compared
// against an independent behavioural model of the requirements.
module tb_vsrc_unit;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [3:0]   elem_size = '0;
    logic [3:0]   modifier = '0;
    logic [127:0] src_vec = '0, bnd_vec = '0, ctl_vec = '0;
    logic         out_valid, cc_valid, spec_err;
    logic [127:0] result;
    logic [1:0]   cc;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic [127:0] model_res = '0;

    always #2 clk = ~clk;

    vsrc_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .elem_size(elem_size), .modifier(modifier),
        .src_vec(src_vec), .bnd_vec(bnd_vec), .ctl_vec(ctl_vec),
        .out_valid(out_valid), .result(result), .cc(cc),
        .cc_valid(cc_valid), .spec_err(spec_err)
    );

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] get_elem(input logic [127:0] v, input int i, input int eb);
        logic [127:0] t;
        t = v >> (128 - 8*eb*(i+1));
        return (eb == 4) ? t[31:0] : (eb == 2) ? {16'h0, t[15:0]} : {24'h0, t[7:0]};
    endfunction

    function automatic logic accept(input logic [31:0] d, input logic [31:0] l, input logic [7:0] c);
        if (d < l) return c[6];
        if (d > l) return c[5];
        return c[7];
    endfunction

    // Behavioural model of R1..R10.
    task automatic model(input logic [127:0] s, b, c, input logic [3:0] es, md,
                         input logic [127:0] prev, output logic [127:0] r,
                         output logic [1:0] ccx, output logic ccv, output logic err);
        int eb, n, fz, fm, lo;
        logic [127:0] mask;
        if (es > 4'd2) begin
            r = prev; ccx = 2'b00; ccv = 1'b0; err = 1'b1;
            return;
        end
        err = 1'b0; eb = 1 << es; n = 16 / eb; fz = 16; fm = 16; mask = '0;
        for (int i = 0; i < n; i++)
            if (md[1] && get_elem(s, i, eb) == 0 && fz == 16) fz = i * eb;
        for (int i = 0; i < n; i++) begin
            logic m;
            logic [31:0] d;
            d = get_elem(s, i, eb);
            m = 1'b0;
            for (int p = 0; p < n / 2; p++) begin
                logic [127:0] c1, c2;
                c1 = c >> (128 - 8*eb*(2*p) - 8);
                c2 = c >> (128 - 8*eb*(2*p+1) - 8);
                if (accept(d, get_elem(b, 2*p, eb), c1[7:0]) &&
                    accept(d, get_elem(b, 2*p+1, eb), c2[7:0])) m = 1'b1;
            end
            m = m ^ md[3];
            if (m) begin
                if (fm == 16) fm = i * eb;
                for (int k = 0; k < eb; k++) mask[127 - 8*(i*eb+k) -: 8] = 8'hFF;
            end
        end
        if (!md[2]) begin
            if (fm >= fz) fm = 16;
            lo = (fm < fz) ? fm : fz;
            r = {64'(lo), 64'h0};
        end else begin
            r = mask;
        end
        ccv = md[0];
        if (!md[0])                  ccx = 2'd0;
        else if (fz == 16 && fm == 16) ccx = 2'd3;
        else if (fz == 16)           ccx = 2'd1;
        else if (fm < fz)            ccx = 2'd2;
        else                         ccx = 2'd0;
    endtask

    // One operation; optional hard-coded expectations for directed cases.
    task automatic run_op(input string tag, input logic [127:0] s, b, c,
                          input logic [3:0] es, md, input bit hard,
                          input logic [127:0] hr, input logic [1:0] hcc,
                          input logic hccv, input logic herr);
        logic [127:0] er;
        logic [1:0]   ecc;
        logic         eccv, eerr;
        model(s, b, c, es, md, model_res, er, ecc, eccv, eerr);
        if (hard) begin er = hr; ecc = hcc; eccv = hccv; eerr = herr; end
        @(negedge clk);
        src_vec = s; bnd_vec = b; ctl_vec = c; elem_size = es; modifier = md;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk({tag, " R11 out_valid"}, 128'(out_valid), 128'(1));
        chk({tag, md[2] ? " R8 result" : " R7 result"}, result, er);
        chk({tag, md[0] ? " R9 cc" : " R10 cc"}, 128'(cc), 128'(ecc));
        chk({tag, " R10 cc_valid"}, 128'(cc_valid), 128'(eccv));
        chk({tag, " R1 spec_err"}, 128'(spec_err), 128'(eerr));
        model_res = er;
        src_vec = ~s;
        @(negedge clk);
        chk({tag, " R11 pulse ends"}, 128'(out_valid), 128'(0));
        chk({tag, " R11 result held"}, result, er);
    endtask

    function automatic logic [127:0] rand_vec();
        logic [127:0] v;
        for (int i = 0; i < 16; i++)
            v[8*i +: 8] = ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'($urandom_range(0, 2));
        return v;
    endfunction

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [127:0] s8;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R12: reset state
        chk("R12 out_valid", 128'(out_valid), 128'(0));
        chk("R12 result", result, 128'h0);
        chk("R12 cc", 128'(cc), 128'(0));
        chk("R12 cc_valid", 128'(cc_valid), 128'(0));
        chk("R12 spec_err", 128'(spec_err), 128'(0));
        rst_n = 1'b1;

        // R4 R3: 8-bit lowercase range, match at 1, zero at 2 (R7, R9 code 2)
        s8 = {8'h41, 8'h62, 8'h00, 8'h63, {12{8'h41}}};
        run_op("D1", s8, {8'h61, 8'h7A, 112'h0}, {8'hA0, 8'hC0, 112'h0}, 4'd0, 4'b0011,
               1, {64'd1, 64'd0}, 2'd2, 1'b1, 1'b0);
        // R8: mask keeps the match after the zero
        run_op("D2", s8, {8'h61, 8'h7A, 112'h0}, {8'hA0, 8'hC0, 112'h0}, 4'd0, 4'b0111,
               1, {8'h00, 8'hFF, 8'h00, 8'hFF, 96'h0}, 2'd2, 1'b1, 1'b0);
        // R6 R7: zero first hides the match, code 0
        s8 = {8'h00, 8'h62, {14{8'h41}}};
        run_op("D3", s8, {8'h61, 8'h7A, 112'h0}, {8'hA0, 8'hC0, 112'h0}, 4'd0, 4'b0011,
               1, 128'h0, 2'd0, 1'b1, 1'b0);
        run_op("D4", s8, {8'h61, 8'h7A, 112'h0}, {8'hA0, 8'hC0, 112'h0}, 4'd0, 4'b0111,
               1, {8'h00, 8'hFF, 112'h0}, 2'd0, 1'b1, 1'b0);
        // R5 R10: inversion of no-match gives all ones, no code
        run_op("D5", {4{32'h1234_5678}}, 128'h0, 128'h0, 4'd2, 4'b1100,
               1, {128{1'b1}}, 2'd0, 1'b0, 1'b0);
        // R9: no match, no zero, code 3 (16-bit)
        run_op("D6", {8{16'h1234}}, 128'h0, 128'h0, 4'd1, 4'b0011,
               1, {64'd16, 64'd0}, 2'd3, 1'b1, 1'b0);
        // R6 R2: search off ignores zero element; match at element 3 = byte 6, code 1
        run_op("D7", {16'h1234, 16'h0000, 16'h1234, 16'h0005, {4{16'h1234}}},
               {16'h0005, 112'h0}, {16'h8000, 16'hE000, 96'h0}, 4'd1, 4'b0001,
               1, {64'd6, 64'd0}, 2'd1, 1'b1, 1'b0);
        // R3: unsigned greater-than on a 32-bit element with top bit set
        run_op("D8", {32'h8000_0000, 96'h0}, {32'h1, 96'h0},
               {32'h2000_0000, 32'hE000_0000, 64'h0}, 4'd2, 4'b0101,
               1, {32'hFFFF_FFFF, 96'h0}, 2'd1, 1'b1, 1'b0);
        // R1: illegal width codes keep the previous result
        run_op("D9", 128'h5, 128'h0, 128'h0, 4'd3, 4'b0111,
               1, {32'hFFFF_FFFF, 96'h0}, 2'd0, 1'b0, 1'b1);
        run_op("D10", 128'h7, 128'h0, 128'h0, 4'd15, 4'b0001,
               1, {32'hFFFF_FFFF, 96'h0}, 2'd0, 1'b0, 1'b1);

        // Random operations checked against the model
        for (int t = 0; t < 400; t++) begin
            logic [3:0] es;
            es = ($urandom_range(0, 15) == 0) ? 4'($urandom_range(3, 15)) : 4'($urandom_range(0, 2));
            run_op("RND", rand_vec(), rand_vec(), 128'($urandom) << ($urandom_range(0, 3) * 32) | {4{$urandom}},
                   es, 4'($urandom), 0, 128'h0, 2'd0, 1'b0, 1'b0);
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule